// File: doc/BRIEF.md
# Audio Master and Bit Clock Divider

This block derives two audio clocks from a single module clock: a master clock for an external converter and a bit clock for the serial audio data path. Each ratio is picked by a 4-bit code from a fixed, non-binary table of division ratios. Every even ratio is produced with an exact 50% duty cycle, and ratio 1 passes the module clock straight through. Alongside the bit clock the block emits a one-cycle tick, in the module clock domain, at the start of each bit clock high phase, which a serializer can use as its bit strobe.

The configuration word holds the master clock code in bits [3:0], the bit clock code in bits [7:4] and a master clock output enable in bit 8. A new code or a new enable value is picked up only at the boundary where the output would next rise, so the pins never see a shortened pulse. A code with no ratio stops its output low and raises an error flag. A parameter selects a narrower ratio table in which the two fields accept fewer codes.

A typical setting runs a 24.576 MHz module clock with a bit clock ratio of 8 (code 5), which gives 64 bit clocks per 48 kHz frame.

Top module: `audio_clk_div`

## Requirements
- R1: In the default (wide) table, code c selects ratio 1, 2, 4, 6, 8, 12, 16, 24, 32, 48, 64, 96, 128, 176, 192 for c = 1 through 15. The master clock code is cfg[3:0] and the bit clock code is cfg[7:4].
- R2: For every ratio N of 2 or more, the output is high for exactly N/2 module clock cycles and then low for exactly N/2 cycles.
- R3: With ratio 1, the output equals the module clock: high in the high half of each module clock cycle and low in the low half.
- R4: A code with no ratio (code 0 in the wide table, or an out-of-range code in the narrow table) holds that output low. cfg_err_o is high from the cycle after such a code is present and is low one cycle after both codes are valid.
- R5: When cfg[8] is clear, mclk_o is held low from the next rising boundary onward. The bit clock keeps running unaffected.
- R6: A code change made partway through a period has no effect until the current high and low phases have completed. The new ratio starts with the next high phase.
- R7: bclk_tick_o is high during exactly the first module clock cycle of each bit clock high phase, and it is high on every cycle while the bit clock ratio is 1.
- R8: With NARROW=1, master clock codes 0 to 7 select ratios 1, 2, 4, 6, 8, 12, 16, 24, and code 8 or above has no ratio. Bit clock codes 0 to 5 select ratios 2, 4, 6, 8, 12, 16, and code 6 or above has no ratio.
- R9: During reset, mclk_o, bclk_o, bclk_tick_o and cfg_err_o are all low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Module clock; all dividers count its rising edges |
| rst_ni | input | 1 | Active-low synchronous reset |
| div_cfg_i | input | 9 | [3:0] master clock code, [7:4] bit clock code, [8] master clock enable |
| mclk_o | output | 1 | Divided master clock |
| bclk_o | output | 1 | Divided bit clock |
| bclk_tick_o | output | 1 | One-cycle strobe at the start of each bit clock high phase |
| cfg_err_o | output | 1 | High while either code has no ratio |

## Verification
The assertions sample the outputs at the module clock edge. They assume the configuration word changes only between edges, and they exclude the pass-through case, because there the output is the clock itself rather than a registered value. The bench changes div_cfg_i only at falling edges and samples the outputs at falling edges. In pass-through mode it also samples one nanosecond after the rising edge, so both halves of the clock are observed without relying on edge ordering.

// File: rtl/aclk_pkg.sv
package aclk_pkg;

    localparam int CODE_W  = 4;
    localparam int RATIO_W = 8;
    localparam int HALF_W  = RATIO_W - 1;
    localparam int CFG_W   = 2 * CODE_W + 1;
    localparam int CODE_TOP = (1 << CODE_W) - 1;

    typedef struct packed {
        logic              run;
        logic              pass;
        logic              level;
        logic              tick;
        logic [HALF_W-1:0] half;
        logic [HALF_W-1:0] cnt;
    } div_state_t;

    typedef struct packed {
        logic err;
    } top_state_t;

    // Wide ratio table; index 0 carries no ratio and returns zero.
    function automatic logic [RATIO_W-1:0] code_ratio(input logic [CODE_W-1:0] code);
        logic [RATIO_W-1:0] r;
        case (code)
            4'd1:    r = 8'd1;
            4'd2:    r = 8'd2;
            4'd3:    r = 8'd4;
            4'd4:    r = 8'd6;
            4'd5:    r = 8'd8;
            4'd6:    r = 8'd12;
            4'd7:    r = 8'd16;
            4'd8:    r = 8'd24;
            4'd9:    r = 8'd32;
            4'd10:   r = 8'd48;
            4'd11:   r = 8'd64;
            4'd12:   r = 8'd96;
            4'd13:   r = 8'd128;
            4'd14:   r = 8'd176;
            4'd15:   r = 8'd192;
            default: r = 8'd0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/aclk_code_map.sv
module aclk_code_map
    import aclk_pkg::*;
#(
    parameter int SHIFT    = 0,
    parameter int CODE_LIM = CODE_TOP
) (
    input  logic [CODE_W-1:0] code_i,
    output logic              ok_o,
    output logic              pass_o,
    output logic [HALF_W-1:0] half_o
);

    localparam int EXT_W = CODE_W + 1;

    logic [EXT_W-1:0]   eff;
    logic [RATIO_W-1:0] ratio;
    logic               in_range;

    always_comb begin
        eff      = EXT_W'(code_i) + EXT_W'(SHIFT);
        in_range = (int'(code_i) <= CODE_LIM) && (int'(eff) <= CODE_TOP);
        ratio    = in_range ? code_ratio(eff[CODE_W-1:0]) : '0;
        ok_o     = (ratio != '0);
        pass_o   = (ratio == RATIO_W'(1));
        half_o   = ratio[RATIO_W-1:1];
    end

endmodule

// File: rtl/aclk_div_unit.sv
module aclk_div_unit
    import aclk_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              go_i,
    input  logic              pass_i,
    input  logic [HALF_W-1:0] half_i,
    output logic              clk_o,
    output logic              tick_o,
    output logic              pass_o
);

    div_state_t st_d, st_q;
    logic       last_cnt;
    logic       rise_pt;

    always_comb begin
        st_d      = st_q;
        st_d.tick = 1'b0;
        last_cnt  = (st_q.cnt == (st_q.half - HALF_W'(1)));
        rise_pt   = !st_q.run || st_q.pass || (last_cnt && !st_q.level);

        if (rise_pt) begin
            // Boundary where the next high phase would begin: reload here.
            st_d.cnt = '0;
            if (go_i) begin
                st_d.run   = 1'b1;
                st_d.pass  = pass_i;
                st_d.half  = half_i;
                st_d.level = 1'b1;
                st_d.tick  = 1'b1;
            end else begin
                st_d.run   = 1'b0;
                st_d.pass  = 1'b0;
                st_d.level = 1'b0;
            end
        end else if (last_cnt) begin
            st_d.level = 1'b0;
            st_d.cnt   = '0;
        end else begin
            st_d.cnt = st_q.cnt + HALF_W'(1);
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pass_o = st_q.run && st_q.pass;
    assign clk_o  = pass_o ? clk_i : st_q.level;
    assign tick_o = st_q.tick;

endmodule

// File: rtl/audio_clk_div.sv
module audio_clk_div
    import aclk_pkg::*;
#(
    parameter bit NARROW = 1'b0
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [CFG_W-1:0] div_cfg_i,
    output logic             mclk_o,
    output logic             bclk_o,
    output logic             bclk_tick_o,
    output logic             cfg_err_o
);

    localparam int MCLK_SHIFT = NARROW ? 1 : 0;
    localparam int MCLK_LIM   = NARROW ? 7 : CODE_TOP;
    localparam int BCLK_SHIFT = NARROW ? 2 : 0;
    localparam int BCLK_LIM   = NARROW ? 5 : CODE_TOP;
    localparam int EN_BIT     = CFG_W - 1;

    logic [CODE_W-1:0] mclk_code, bclk_code;
    logic              mclk_ok, mclk_pass_sel, bclk_ok, bclk_pass_sel;
    logic [HALF_W-1:0] mclk_half, bclk_half;
    logic              mclk_pass, bclk_pass;
    logic              mclk_tick_unused;
    top_state_t        ts_d, ts_q;

    assign mclk_code = div_cfg_i[CODE_W-1:0];
    assign bclk_code = div_cfg_i[2*CODE_W-1:CODE_W];

    aclk_code_map #(.SHIFT(MCLK_SHIFT), .CODE_LIM(MCLK_LIM)) u_mclk_map (
        .code_i (mclk_code),
        .ok_o   (mclk_ok),
        .pass_o (mclk_pass_sel),
        .half_o (mclk_half)
    );

    aclk_code_map #(.SHIFT(BCLK_SHIFT), .CODE_LIM(BCLK_LIM)) u_bclk_map (
        .code_i (bclk_code),
        .ok_o   (bclk_ok),
        .pass_o (bclk_pass_sel),
        .half_o (bclk_half)
    );

    aclk_div_unit u_mclk_div (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .go_i   (mclk_ok && div_cfg_i[EN_BIT]),
        .pass_i (mclk_pass_sel),
        .half_i (mclk_half),
        .clk_o  (mclk_o),
        .tick_o (mclk_tick_unused),
        .pass_o (mclk_pass)
    );

    aclk_div_unit u_bclk_div (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .go_i   (bclk_ok),
        .pass_i (bclk_pass_sel),
        .half_i (bclk_half),
        .clk_o  (bclk_o),
        .tick_o (bclk_tick_o),
        .pass_o (bclk_pass)
    );

    always_comb begin
        ts_d     = ts_q;
        ts_d.err = !mclk_ok || !bclk_ok;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            ts_q <= '0;
        end else begin
            ts_q <= ts_d;
        end
    end

    assign cfg_err_o = ts_q.err;

endmodule

// File: rtl/audio_clk_div_chk.sv
module audio_clk_div_chk
    import aclk_pkg::*;
#(
    parameter bit NARROW = 1'b0
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic [CFG_W-1:0] div_cfg_i,
    input logic             mclk_o,
    input logic             bclk_o,
    input logic             bclk_tick_o,
    input logic             cfg_err_o,
    input logic             mclk_pass_i,
    input logic             bclk_pass_i
);

    // R7
    tick_on_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bclk_tick_o && !bclk_pass_i) |-> bclk_o);

    // R7
    tick_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bclk_tick_o && !bclk_pass_i) |=> !bclk_tick_o);

    // R5
    mclk_off_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!div_cfg_i[CFG_W-1] && !mclk_pass_i && !mclk_o) |=> !mclk_o);

    // R4
    zero_code_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!NARROW && (div_cfg_i[CODE_W-1:0] == '0)) |=> cfg_err_o);

    // R4
    bclk_zero_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!NARROW && (div_cfg_i[2*CODE_W-1:CODE_W] == '0) && !bclk_pass_i && !bclk_o)
        |=> !bclk_o);

endmodule

bind audio_clk_div audio_clk_div_chk #(.NARROW(NARROW)) u_audio_clk_div_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .div_cfg_i   (div_cfg_i),
    .mclk_o      (mclk_o),
    .bclk_o      (bclk_o),
    .bclk_tick_o (bclk_tick_o),
    .cfg_err_o   (cfg_err_o),
    .mclk_pass_i (mclk_pass),
    .bclk_pass_i (bclk_pass)
);

// File: tb/audio_clk_div_bench.sv
`timescale 1ns/1ps
module audio_clk_div_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [8:0] cfg_w = '0;
    logic [8:0] cfg_n = '0;
    logic       mclk_w, bclk_w, tick_w, err_w;
    logic       mclk_n, bclk_n, tick_n, err_n;
    int         n_tests = 0;
    int         n_fail  = 0;
    int         cycles  = 0;
    bit         done    = 1'b0;

    always #2.5 clk = ~clk;

    audio_clk_div #(.NARROW(1'b0)) u_audio_clk_div (
        .clk_i(clk), .rst_ni(rst_n), .div_cfg_i(cfg_w),
        .mclk_o(mclk_w), .bclk_o(bclk_w), .bclk_tick_o(tick_w), .cfg_err_o(err_w));

    audio_clk_div #(.NARROW(1'b1)) u_audio_clk_div_narrow (
        .clk_i(clk), .rst_ni(rst_n), .div_cfg_i(cfg_n),
        .mclk_o(mclk_n), .bclk_o(bclk_n), .bclk_tick_o(tick_n), .cfg_err_o(err_n));

    // Wide ratio from the R1 list: 1, 2, then 2^k on odd codes and 3*2^k on even codes.
    function automatic int wide_ratio(input int c);
        if (c == 1) return 1;
        if (c == 2) return 2;
        if (c == 14) return 176;
        if (c == 15) return 192;
        if (c % 2 == 1) return 1 << ((c + 1) / 2);
        return 3 * (1 << ((c - 2) / 2));
    endfunction

    function automatic logic pick(input int sel);
        case (sel)
            0: return mclk_w;
            1: return bclk_w;
            2: return mclk_n;
            default: return bclk_n;
        endcase
    endfunction

    function automatic logic pick_tick(input int sel);
        return (sel == 1) ? tick_w : tick_n;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Measure one full period after the next rising boundary.
    task automatic measure(input int sel, input int ratio, input string req);
        logic prev, cur;
        int   hi, lo, guard, ticks;
        bit   has_tick;
        has_tick = (sel == 1) || (sel == 3);
        if (ratio == 0) begin
            wait_cyc(420);
            hi = 0;
            for (int i = 0; i < 400; i++) begin
                @(negedge clk);
                if (pick(sel)) hi++;
            end
            check(hi == 0, req, hi, 0);
        end else if (ratio == 1) begin
            wait_cyc(420);
            @(posedge clk); #1;
            check(pick(sel) == 1'b1, {req, " pass high"}, int'(pick(sel)), 1);
            @(negedge clk); #1;
            check(pick(sel) == 1'b0, {req, " pass low"}, int'(pick(sel)), 0);
            if (has_tick) check(pick_tick(sel) == 1'b1, "R7 tick in pass", int'(pick_tick(sel)), 1);
        end else begin
            @(negedge clk);
            prev  = pick(sel);
            guard = 0;
            cur   = prev;
            while (guard < 1000) begin
                @(negedge clk);
                cur = pick(sel);
                if (!prev && cur) break;
                prev = cur;
                guard++;
            end
            if (has_tick) check(pick_tick(sel) == 1'b1, "R7 tick at rise", int'(pick_tick(sel)), 1);
            hi = 1; lo = 0; ticks = 0;
            forever begin
                @(negedge clk);
                if (has_tick && pick_tick(sel)) ticks++;
                if (!pick(sel)) break;
                hi++;
                if (hi > 400) break;
            end
            lo = 1;
            forever begin
                @(negedge clk);
                if (pick(sel)) break;
                if (has_tick && pick_tick(sel)) ticks++;
                lo++;
                if (lo > 400) break;
            end
            check(hi == ratio / 2, {req, " high"}, hi, ratio / 2);
            check(lo == ratio / 2, {req, " low"}, lo, ratio / 2);
            if (has_tick) check(ticks == 0, "R7 one tick per period", ticks, 0);
        end
    endtask

    initial begin
        logic [8:0] c9;
        int hi, lo;
        wait_cyc(3);
        // R9 reset state
        check(mclk_w == 0 && bclk_w == 0 && tick_w == 0 && err_w == 0, "R9 reset",
              int'({mclk_w, bclk_w, tick_w, err_w}), 0);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 R2 R3 sweep of the wide table on both fields
        for (int c = 1; c <= 15; c++) begin
            c9 = 9'h100 | 9'(c << 4) | 9'(c);
            cfg_w = c9;
            measure(0, wide_ratio(c), $sformatf("R1 R2 R3 mclk code %0d", c));
            measure(1, wide_ratio(c), $sformatf("R1 R2 R3 bclk code %0d", c));
            check(err_w == 1'b0, "R4 err low on valid", int'(err_w), 0);
        end

        // R1 fields are independent: mclk code 3 (4), bclk code 6 (12)
        cfg_w = 9'h163;
        measure(0, 4, "R1 mclk field");
        measure(1, 12, "R1 bclk field");

        // R4 zero codes
        cfg_w = 9'h150;
        wait_cyc(2);
        check(err_w == 1'b1, "R4 err on mclk code 0", int'(err_w), 1);
        measure(0, 0, "R4 mclk code 0 low");
        measure(1, 8, "R4 bclk unaffected");
        cfg_w = 9'h105;
        wait_cyc(2);
        check(err_w == 1'b1, "R4 err on bclk code 0", int'(err_w), 1);
        measure(1, 0, "R4 bclk code 0 low");
        check(tick_w == 1'b0, "R7 no tick when stopped", int'(tick_w), 0);
        cfg_w = 9'h155;
        wait_cyc(2);
        check(err_w == 1'b0, "R4 err clears", int'(err_w), 0);

        // R5 enable clear
        cfg_w = 9'h055;
        measure(0, 0, "R5 mclk disabled low");
        check(err_w == 1'b0, "R5 no err when disabled", int'(err_w), 0);
        measure(1, 8, "R5 bclk keeps running");
        cfg_w = 9'h155;
        measure(0, 8, "R5 mclk re-enabled");

        // R6 change mid high phase: 32 -> 4
        cfg_w = 9'h195;
        wait_cyc(400);
        while (!(bclk_w == 1'b0)) @(negedge clk);
        while (!(bclk_w == 1'b1)) @(negedge clk);
        hi = 1;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            if (bclk_w) hi++;
        end
        cfg_w = 9'h135;
        while (1) begin
            @(negedge clk);
            if (!bclk_w) break;
            hi++;
        end
        lo = 1;
        while (1) begin
            @(negedge clk);
            if (bclk_w) break;
            lo++;
        end
        check(hi == 16, "R6 old high phase kept", hi, 16);
        check(lo == 16, "R6 old low phase kept", lo, 16);
        hi = 1;
        while (1) begin
            @(negedge clk);
            if (!bclk_w) break;
            hi++;
        end
        check(hi == 2, "R6 new ratio after rise", hi, 2);

        // R8 narrow table
        for (int c = 0; c <= 7; c++) begin
            cfg_n = 9'h100 | 9'((c % 6) << 4) | 9'(c);
            measure(2, wide_ratio(c + 1), $sformatf("R8 narrow mclk code %0d", c));
            measure(3, wide_ratio((c % 6) + 2), $sformatf("R8 narrow bclk code %0d", c % 6));
        end
        cfg_n = 9'h108;
        wait_cyc(2);
        check(err_n == 1'b1, "R8 narrow mclk code 8 err", int'(err_n), 1);
        measure(2, 0, "R8 narrow mclk code 8 low");
        cfg_n = 9'h162;
        wait_cyc(2);
        check(err_n == 1'b1, "R8 narrow bclk code 6 err", int'(err_n), 1);
        measure(3, 0, "R8 narrow bclk code 6 low");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 180000 && !done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 180000);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule